// File: doc/BRIEF.md
# Serial Control Register Port for a Clock Generator

This block is a serial slave port that lets a host processor write and read a bank of nine 8-bit configuration registers in a clock-generator controller. The host frames every access with an active-low chip select and exchanges one 16-bit word per frame over serial clock, data-in and data-out pins. Inside that word, a direction flag and a 7-bit register address come first, and an 8-bit data field follows. On a read frame, the addressed register is returned on the data-out pin during the second half of the same frame.

The register contents leave the block as a flat vector. The block also decodes one control register into a drive mode for each of two clock outputs. A global bit forces the enabled outputs to a static low level. A per-output disable bit puts that output into high impedance, and this takes precedence over the global bit.

The serial pins are asynchronous to the block clock. They pass through a two-stage synchronizer, and their edges are detected in the block clock domain. The block clock must therefore be many times faster than the serial clock: a 2 MHz serial clock needs a block clock in the tens of MHz or higher.

Top module: `spiCfgPort`

## Requirements
- R1: A frame begins when csN falls. sdi is sampled on each rising sclk edge, most significant bit first. Bit 15 is the direction flag (1 = read, 0 = write), bits 14 to 8 are the register address, and bits 7 to 0 are the data.
- R2: A write frame with an address from 0 to 8 stores its data byte into that register once the 16th rising edge has been seen. Register n appears on cfgRegs bits [8n+7:8n].
- R3: A write frame with an address from 9 to 127 changes no register.
- R4: In a read frame, sdo carries the addressed register, most significant bit first. The first bit is valid before the 9th rising sclk edge, and sdo advances on each falling edge after that. A read frame leaves every register unchanged.
- R5: A read frame with an address from 9 to 127 returns zero on sdo.
- R6: If csN rises before the 16th rising sclk edge, the frame is dropped and no register changes.
- R7: While rstN is low, all registers clear to zero, both outputs are in clock mode, and sdo is low.
- R8: Each output has a 2-bit drive code: 00 = drive the clock, 01 = static low, 10 = high impedance. Output k uses outDrive bits [2k+1:2k]. When bit 7 of register 5 is set, every output that is not disabled uses code 01.
- R9: Bit 6 of register 5 disables output 0 and bit 5 disables output 1. A disabled output uses code 10, whatever the value of bit 7.
- R10: sdo stays low in write frames, outside the data half of a read frame, and while csN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| cfgRegs | output | 72 | Register bank, register n at bits [8n+7:8n] |
| outDrive | output | 4 | Drive code per clock output, 2 bits each |

## Verification
The bench builds the block with its default parameters: nine registers, a 7-bit address and two clock outputs. With these values every address from 0 to 127 can be reached, including the out-of-range span 9 to 127, and all combinations of the three gating bits in register 5 can be exercised. The serial clock runs at 40 block-clock cycles per period. This leaves wide margins around the synchronizer latency, so the data-out timing can be checked exactly at the host's sampling points. Random frames are mixed with directed ones, and some random frames are aborted at a random bit count.

// File: rtl/spiCfgPkg.sv
package spiCfgPkg;

  // Drive code for one clock output
  typedef enum logic [1:0] {
    DRV_CLOCK = 2'b00,
    DRV_LOW   = 2'b01,
    DRV_HIZ   = 2'b10
  } drvMode_e;

  // Strobes from the frame controller to the datapath
  typedef struct packed {
    logic clear;    // chip select inactive: drop the partial frame
    logic shiftIn;  // capture one serial input bit
    logic loadTx;   // header complete: load the read shifter
    logic shiftTx;  // advance the read shifter
    logic commit;   // last bit captured: act on the full word
  } ctrlStrobe_t;

endpackage

// File: rtl/spiCfgCtrl.sv
module spiCfgCtrl
  import spiCfgPkg::*;
#(
  parameter int FRAME_W     = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        sdi,
  output logic        sdiBit,
  output ctrlStrobe_t strobe
);

  localparam int HDR_W = FRAME_W - DATA_W;
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [SYNC_STAGES-1:0] csSync, sclkSync, sdiSync;
  logic                   sclkPrev;
  logic                   csHigh, sclkRise, sclkFall;
  logic [CNT_W-1:0]       bitCnt;

  // Equal-depth synchronizers keep data aligned with the detected clock edge
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          csSync   <= '1;
          sclkSync <= '0;
          sdiSync  <= '0;
        end else begin
          csSync   <= csN;
          sclkSync <= sclk;
          sdiSync  <= sdi;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          csSync   <= '1;
          sclkSync <= '0;
          sdiSync  <= '0;
        end else begin
          csSync   <= {csSync[SYNC_STAGES-2:0], csN};
          sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclk};
          sdiSync  <= {sdiSync[SYNC_STAGES-2:0], sdi};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkSync[SYNC_STAGES-1];
  end

  assign csHigh   = csSync[SYNC_STAGES-1];
  assign sdiBit   = sdiSync[SYNC_STAGES-1];
  assign sclkRise = sclkSync[SYNC_STAGES-1] & ~sclkPrev;
  assign sclkFall = ~sclkSync[SYNC_STAGES-1] & sclkPrev;

  // Rising-edge counter; it saturates at a full frame until chip select lifts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              bitCnt <= '0;
    else if (csHigh)        bitCnt <= '0;
    else if (strobe.shiftIn) bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    strobe         = '0;
    strobe.clear   = csHigh;
    strobe.shiftIn = sclkRise && !csHigh && (bitCnt < CNT_W'(FRAME_W));
    strobe.loadTx  = strobe.shiftIn && (bitCnt == CNT_W'(HDR_W - 1));
    strobe.commit  = strobe.shiftIn && (bitCnt == CNT_W'(FRAME_W - 1));
    strobe.shiftTx = sclkFall && !csHigh && (bitCnt > CNT_W'(HDR_W))
                     && (bitCnt < CNT_W'(FRAME_W));
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(FRAME_W)); // R1
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> (bitCnt == '0)); // R6
  AST_NO_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |-> !strobe.commit); // R6

endmodule

// File: rtl/spiCfgData.sv
module spiCfgData
  import spiCfgPkg::*;
#(
  parameter int FRAME_W    = 16,
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 8,
  parameter int NUM_REGS   = 9,
  parameter int NUM_OUTS   = 2,
  parameter int CTRL_REG   = 5,
  parameter int FORCE_BIT  = 7,
  parameter int HIZ_TOP    = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sdiBit,
  input  ctrlStrobe_t                  strobe,
  output logic                         sdo,
  output logic [NUM_REGS*DATA_W-1:0]   cfgRegs,
  output logic [2*NUM_OUTS-1:0]        outDrive
);

  localparam int HDR_W = FRAME_W - DATA_W;

  logic [FRAME_W-2:0]                  rxShift;
  logic [HDR_W-1:0]                    hdrWord;
  logic [FRAME_W-1:0]                  fullWord;
  logic [NUM_REGS-1:0][DATA_W-1:0]     regBank;
  logic [DATA_W-1:0]                   txShift;
  logic [DATA_W-1:0]                   rdSel;
  logic                                hdrRead, fullRead;
  logic [ADDR_W-1:0]                   hdrAddr, fullAddr;
  logic [DATA_W-1:0]                   fullData;

  // Words as they stand once the current bit is included
  assign hdrWord  = {rxShift[HDR_W-2:0], sdiBit};
  assign fullWord = {rxShift, sdiBit};
  assign hdrRead  = hdrWord[HDR_W-1];
  assign hdrAddr  = hdrWord[ADDR_W-1:0];
  assign fullRead = fullWord[FRAME_W-1];
  assign fullAddr = fullWord[DATA_W +: ADDR_W];
  assign fullData = fullWord[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rxShift <= '0;
    else if (strobe.clear)  rxShift <= '0;
    else if (strobe.shiftIn) rxShift <= fullWord[FRAME_W-2:0];
  end

  // Register bank: only full write frames to an implemented address land
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regBank <= '0;
    end else if (strobe.commit && !fullRead) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (fullAddr == ADDR_W'(i)) regBank[i] <= fullData;
      end
    end
  end

  // Read selection; unimplemented addresses read as zero
  always_comb begin
    rdSel = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hdrAddr == ADDR_W'(i)) rdSel = regBank[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               txShift <= '0;
    else if (strobe.clear)   txShift <= '0;
    else if (strobe.loadTx)  txShift <= hdrRead ? rdSel : '0;
    else if (strobe.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b0};
  end

  assign sdo     = txShift[DATA_W-1];
  assign cfgRegs = regBank;

  // Output gating: a per-output disable wins over the global force-low
  generate
    for (genvar k = 0; k < NUM_OUTS; k++) begin : g_gate
      logic outHiz, outLow;
      assign outHiz = regBank[CTRL_REG][HIZ_TOP - k];
      assign outLow = regBank[CTRL_REG][FORCE_BIT];
      always_comb begin
        if (outHiz)      outDrive[2*k +: 2] = DRV_HIZ;
        else if (outLow) outDrive[2*k +: 2] = DRV_LOW;
        else             outDrive[2*k +: 2] = DRV_CLOCK;
      end
      AST_HIZ_WINS: assert property (@(posedge clk) disable iff (!rstN)
        regBank[CTRL_REG][HIZ_TOP - k] |-> (outDrive[2*k +: 2] == DRV_HIZ)); // R9
      AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rstN)
        (regBank[CTRL_REG][FORCE_BIT] && !regBank[CTRL_REG][HIZ_TOP - k])
        |-> (outDrive[2*k +: 2] == DRV_LOW)); // R8
    end
  endgenerate

  AST_NO_OOR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && (fullAddr >= ADDR_W'(NUM_REGS))) |=> $stable(regBank)); // R3
  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && fullRead) |=> $stable(regBank)); // R4
  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> !sdo); // R10
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(regBank)); // R2

endmodule

// File: rtl/spiCfgPort.sv
module spiCfgPort
  import spiCfgPkg::*;
#(
  parameter int FRAME_W     = 16,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int NUM_REGS    = 9,
  parameter int NUM_OUTS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       csN,
  input  logic                       sclk,
  input  logic                       sdi,
  output logic                       sdo,
  output logic [NUM_REGS*DATA_W-1:0] cfgRegs,
  output logic [2*NUM_OUTS-1:0]      outDrive
);

  ctrlStrobe_t strobe;
  logic        sdiBit;

  spiCfgCtrl #(
    .FRAME_W    (FRAME_W),
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .csN   (csN),
    .sclk  (sclk),
    .sdi   (sdi),
    .sdiBit(sdiBit),
    .strobe(strobe)
  );

  spiCfgData #(
    .FRAME_W (FRAME_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .NUM_OUTS(NUM_OUTS)
  ) data_i (
    .clk     (clk),
    .rstN    (rstN),
    .sdiBit  (sdiBit),
    .strobe  (strobe),
    .sdo     (sdo),
    .cfgRegs (cfgRegs),
    .outDrive(outDrive)
  );

endmodule

// File: tb/spiCfgPort_tb_top.sv
module spiCfgPort_tb_top;

  localparam int HALF  = 20;
  localparam int NREGS = 9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo;
  logic [71:0] cfgRegs;
  logic [3:0]  outDrive;

  int nChecks = 0;
  int nErr = 0;
  logic [7:0] model [NREGS];

  always #2.5 clk = ~clk;

  spiCfgPort dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .cfgRegs(cfgRegs), .outDrive(outDrive)
  );

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expDrive(input logic [7:0] cr);
    logic [3:0] r;
    for (int k = 0; k < 2; k++) begin
      if (cr[6-k])   r[2*k +: 2] = 2'b10;
      else if (cr[7]) r[2*k +: 2] = 2'b01;
      else           r[2*k +: 2] = 2'b00;
    end
    return r;
  endfunction

  function automatic logic [71:0] expRegs();
    logic [71:0] v;
    for (int i = 0; i < NREGS; i++) v[8*i +: 8] = model[i];
    return v;
  endfunction

  function automatic logic [7:0] expRead(input logic [6:0] a);
    return (a < NREGS) ? model[a] : 8'h00;
  endfunction

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Shift nBits of word; sdo is sampled just before each rising edge of the data half
  task automatic spiFrame(input logic [15:0] word, input int nBits, output logic [7:0] rd);
    rd = 8'h00;
    csN = 1'b0;
    waitCyc(HALF);
    for (int i = 0; i < nBits; i++) begin
      sdi = word[15-i];
      waitCyc(HALF);
      if (i >= 8) rd[15-i] = sdo;
      sclk = 1'b1;
      waitCyc(HALF);
      sclk = 1'b0;
    end
    waitCyc(HALF);
    csN = 1'b1;
    sdi = 1'b0;
    waitCyc(HALF);
  endtask

  // Full frame with model update and checks
  task automatic doFrame(input logic rw, input logic [6:0] a, input logic [7:0] d, input int nBits);
    logic [7:0] rd;
    logic [7:0] expRd;
    expRd = rw ? expRead(a) : 8'h00;
    spiFrame({rw, a, d}, nBits, rd);
    if (nBits == 16) begin
      if (rw) chk(a < NREGS ? "R4 read data" : "R5 out-of-range read", {64'd0, rd}, {64'd0, expRd});
      else    chk("R10 sdo quiet in write", {64'd0, rd}, 72'd0);
      if (!rw && a < NREGS) model[a] = d;
      chk(rw ? "R4 read keeps regs" : (a < NREGS ? "R2 write" : "R3 ignored write"),
          cfgRegs, expRegs());
    end else begin
      chk("R6 aborted frame", cfgRegs, expRegs());
    end
    chk("R8 R9 drive codes", {68'd0, outDrive}, {68'd0, expDrive(model[5])});
    chk("R10 sdo idle", {71'd0, sdo}, 72'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
    waitCyc(4);
    // R7 reset state
    chk("R7 regs zero", cfgRegs, 72'd0);
    chk("R7 outputs clock", {68'd0, outDrive}, 72'd0);
    chk("R7 sdo low", {71'd0, sdo}, 72'd0);
    rstN = 1'b1;
    waitCyc(4);

    // R1 R2 bit order: distinct patterns in every register
    for (int i = 0; i < NREGS; i++) doFrame(1'b0, 7'(i), 8'hA1 + 8'(i*17), 16);
    for (int i = 0; i < NREGS; i++) doFrame(1'b1, 7'(i), 8'h00, 16);
    // R8 R9 gating combinations in register 5
    doFrame(1'b0, 7'd5, 8'h80, 16);
    chk("R8 both forced low", {68'd0, outDrive}, 72'h5);
    doFrame(1'b0, 7'd5, 8'hC0, 16);
    chk("R9 out0 hiz over force", {68'd0, outDrive}, 72'h6);
    doFrame(1'b0, 7'd5, 8'hA0, 16);
    chk("R9 out1 hiz over force", {68'd0, outDrive}, 72'h9);
    doFrame(1'b0, 7'd5, 8'h60, 16);
    chk("R9 both hiz", {68'd0, outDrive}, 72'hA);
    doFrame(1'b0, 7'd5, 8'h1F, 16);
    chk("R8 clock mode", {68'd0, outDrive}, 72'h0);
    // R3 R5 out-of-range edges
    doFrame(1'b0, 7'd9, 8'hFF, 16);
    doFrame(1'b0, 7'd127, 8'hFF, 16);
    doFrame(1'b1, 7'd9, 8'h00, 16);
    doFrame(1'b1, 7'd127, 8'h00, 16);
    // R6 abort one bit short
    doFrame(1'b0, 7'd2, 8'h3C, 15);
    doFrame(1'b1, 7'd2, 8'h00, 16);

    // Random mix
    for (int n = 0; n < 90; n++) begin
      logic rw;
      logic [6:0] a;
      int bits;
      rw = 1'($urandom_range(0, 2) == 0);
      case ($urandom_range(0, 5))
        0: a = 7'd5;
        1: a = 7'($urandom_range(9, 127));
        default: a = 7'($urandom_range(0, 8));
      endcase
      bits = ($urandom_range(0, 4) == 0) ? $urandom_range(1, 15) : 16;
      doFrame(rw, a, 8'($urandom), bits);
    end

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule